// File: doc/BRIEF.md
# Compressed Branch Trace Encoder

This block observes the instruction retire stream of a processor core and produces trace messages only for retirements that change program flow. A debugger can rebuild the program path from these messages. Most messages carry their target address compressed against the address carried by the message sent just before. Full-address synchronisation messages are inserted so that a decoder can recover its base address.

Messages enter a 16-entry queue. A ready/valid port drains the queue toward an auxiliary output link. The queue absorbs bursts of flow changes that arrive faster than the link drains them. When the queue runs short of space, one of two policies applies. In stall mode, a stall request is raised early enough that nothing is lost. In drop mode, messages are discarded, an error message is queued once space returns, and the next message is a full-address sync.

Trace is gated by an enable level and by start and stop pulses from the watchpoint logic.

Top module: `brtrace_enc`

## Requirements
- R1: While reset is held and on the first cycle after it, `msg_valid` and `core_stall` are low.
- R2: Flow codes on `ret_flow` are: 0 sequential, 1 jump, 2 taken branch, 3 not-taken branch, 4 interrupt, 5 exception, 6 return, 7 load into the PC. Codes 1, 2, 4, 5, 6 and 7 each produce one message whose `msg_flow` equals the code. Codes 0 and 3 produce nothing.
- R3: Tracing becomes active on the cycle after a `trc_start` pulse seen while `trc_en` is high. It ends on the cycle after a `trc_stop` pulse, or whenever `trc_en` is low. No message is produced for a retirement while tracing is inactive.
- R4: The first message after each start is a sync message: `msg_kind`=2, `msg_len`=3, and `msg_addr` holding the absolute target.
- R5: A normal message has `msg_kind`=1. Its `msg_addr` is the target XOR the address of the previous queued message. Its `msg_len` is the index of the highest non-zero byte of that XOR, or 0 when the XOR is zero. Bytes above `msg_len` are zero.
- R6: Once 256 normal messages have been queued since the last sync message, the next message is a sync message.
- R7: Messages leave in generation order. While `msg_valid` is high and `msg_ready` is low, the message is held unchanged.
- R8: The queue stores 16 messages, plus one presented at the output. With `ovf_stall` low, a flow change that finds the store full is dropped. From then on, every flow change is dropped until a free entry appears. On that cycle an error message is queued (`msg_kind`=3, flow 0, length 0, address 0), and a flow change in that same cycle is also dropped.
- R9: The message after an error message is a sync message.
- R10: With `ovf_stall` high, `core_stall` is high exactly when 2 or fewer of the 16 store entries are free. The output follows the fill level with one cycle of delay. With `ovf_stall` low, `core_stall` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_en | input | 1 | Trace enable level |
| trc_start | input | 1 | Start pulse from watchpoint logic |
| trc_stop | input | 1 | Stop pulse from watchpoint logic |
| ovf_stall | input | 1 | 1: stall policy, 0: drop policy |
| ret_valid | input | 1 | A retirement is presented this cycle |
| ret_flow | input | 3 | Flow-change code of the retirement |
| ret_target | input | 32 | Address execution continues at |
| core_stall | output | 1 | Request that the core stop retiring |
| msg_valid | output | 1 | A message is presented |
| msg_ready | input | 1 | Output link accepts the message |
| msg_kind | output | 2 | 1 normal, 2 sync, 3 error |
| msg_flow | output | 3 | Flow code carried by the message |
| msg_len | output | 2 | Significant bytes minus one |
| msg_addr | output | 32 | Compressed or absolute address |

## Verification
The hardest state to reach from the ports is the drop-and-recover path. It needs a full store, a pending error that outlives several more flow changes, and the cycle when space reappears. The bench holds `msg_ready` low and issues flow changes two cycles apart. This makes the fill level exact: seventeen messages are accepted and three are dropped. The bench then releases the link and expects the error followed by a sync. Stall thresholds are reached the same way, stopping one message before and one at the margin.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;

  typedef enum logic [1:0] {
    MK_NONE = 2'd0,
    MK_NORM = 2'd1,
    MK_SYNC = 2'd2,
    MK_ERR  = 2'd3
  } mkind_e;

  localparam logic [2:0] FL_SEQ    = 3'd0;
  localparam logic [2:0] FL_NTAKEN = 3'd3;

  // Sequential retirement and not-taken branches do not change flow.
  function automatic logic is_flow_change(input logic [2:0] code);
    return (code != FL_SEQ) && (code != FL_NTAKEN);
  endfunction

endpackage

// File: rtl/brtrace_fmt.sv
module brtrace_fmt #(
  parameter int AW = 32,
  localparam int NB = AW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] diff,
  output logic [LW-1:0] len
);

  logic [NB-1:0] byte_nz;

  assign diff = target ^ base;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_byte
      assign byte_nz[b] = |diff[8*b +: 8];
    end
  endgenerate

  // Highest non-zero byte wins; all-zero collapses to one byte.
  always_comb begin
    len = '0;
    for (int i = 1; i < NB; i++) begin
      if (byte_nz[i]) len = LW'(i);
    end
  end

endmodule

// File: rtl/brtrace_ctrl.sv
module brtrace_ctrl
  import brtrace_pkg::*;
#(
  parameter int AW          = 32,
  parameter int SYNC_PERIOD = 256,
  localparam int NB = AW / 8,
  localparam int LW = $clog2(NB),
  localparam int CW = $clog2(SYNC_PERIOD + 1),
  localparam int MW = 2 + 3 + LW + AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trc_en,
  input  logic          trc_start,
  input  logic          trc_stop,
  input  logic          ret_valid,
  input  logic [2:0]    ret_flow,
  input  logic [AW-1:0] ret_target,
  input  logic          q_full,
  output logic          push,
  output logic [MW-1:0] push_word
);

  logic          active;
  logic          need_sync;
  logic          err_pend;
  logic [AW-1:0] last_addr;
  logic [CW-1:0] norm_cnt;

  logic [AW-1:0] rel_addr;
  logic [LW-1:0] rel_len;
  logic          hit;
  logic          want_sync;

  brtrace_fmt #(.AW(AW)) u_fmt (
    .target (ret_target),
    .base   (last_addr),
    .diff   (rel_addr),
    .len    (rel_len)
  );

  assign hit       = active && ret_valid && is_flow_change(ret_flow);
  assign want_sync = need_sync || (norm_cnt == CW'(SYNC_PERIOD));

  always_comb begin
    push      = 1'b0;
    push_word = '0;
    if (err_pend) begin
      if (!q_full) begin
        push      = 1'b1;
        push_word = {MK_ERR, 3'd0, {LW{1'b0}}, {AW{1'b0}}};
      end
    end else if (hit && !q_full) begin
      push = 1'b1;
      if (want_sync) push_word = {MK_SYNC, ret_flow, LW'(NB - 1), ret_target};
      else           push_word = {MK_NORM, ret_flow, rel_len, rel_addr};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      need_sync <= 1'b1;
      err_pend  <= 1'b0;
      last_addr <= '0;
      norm_cnt  <= '0;
    end else begin
      if (!trc_en)        active <= 1'b0;
      else if (trc_stop)  active <= 1'b0;
      else if (trc_start) active <= 1'b1;

      if (err_pend) begin
        if (!q_full) begin
          err_pend  <= 1'b0;
          need_sync <= 1'b1;
        end
      end else if (hit) begin
        if (q_full) begin
          err_pend <= 1'b1;
        end else begin
          last_addr <= ret_target;
          if (want_sync) begin
            need_sync <= 1'b0;
            norm_cnt  <= '0;
          end else begin
            norm_cnt <= norm_cnt + 1'b1;
          end
        end
      end

      if (trc_en && trc_start) need_sync <= 1'b1;
    end
  end

endmodule

// File: rtl/brtrace_queue.sv
module brtrace_queue #(
  parameter int W      = 39,
  parameter int DEPTH  = 16,
  parameter int MARGIN = 2,
  localparam int PW  = $clog2(DEPTH),
  localparam int CTW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [W-1:0]   push_word,
  input  logic           stall_mode,
  output logic           q_full,
  output logic [CTW-1:0] q_cnt,
  output logic           stall,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_word
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic          load;

  assign q_full = (q_cnt == CTW'(DEPTH));
  assign load   = (q_cnt != '0) && (!out_valid || out_ready);

  // Storage and read register without reset: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
    if (load) out_word    <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      q_cnt     <= '0;
      out_valid <= 1'b0;
      stall     <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (load) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;

      if (push && !load)      q_cnt <= q_cnt + 1'b1;
      else if (!push && load) q_cnt <= q_cnt - 1'b1;

      if (load)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;

      stall <= stall_mode && ((CTW'(DEPTH) - q_cnt) <= CTW'(MARGIN));
    end
  end

endmodule

// File: rtl/brtrace_enc.sv
module brtrace_enc
  import brtrace_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DEPTH        = 16,
  parameter int SYNC_PERIOD  = 256,
  parameter int STALL_MARGIN = 2,
  localparam int LW  = $clog2(AW / 8),
  localparam int MW  = 2 + 3 + LW + AW,
  localparam int CTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trc_en,
  input  logic          trc_start,
  input  logic          trc_stop,
  input  logic          ovf_stall,
  input  logic          ret_valid,
  input  logic [2:0]    ret_flow,
  input  logic [AW-1:0] ret_target,
  output logic          core_stall,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [1:0]    msg_kind,
  output logic [2:0]    msg_flow,
  output logic [LW-1:0] msg_len,
  output logic [AW-1:0] msg_addr
);

  logic           push;
  logic [MW-1:0]  push_word;
  logic [1:0]     push_kind;
  logic           q_full;
  logic [CTW-1:0] q_cnt;
  logic [MW-1:0]  out_word;

  assign push_kind = push_word[MW-1 -: 2];

  brtrace_ctrl #(.AW(AW), .SYNC_PERIOD(SYNC_PERIOD)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .trc_en     (trc_en),
    .trc_start  (trc_start),
    .trc_stop   (trc_stop),
    .ret_valid  (ret_valid),
    .ret_flow   (ret_flow),
    .ret_target (ret_target),
    .q_full     (q_full),
    .push       (push),
    .push_word  (push_word)
  );

  brtrace_queue #(.W(MW), .DEPTH(DEPTH), .MARGIN(STALL_MARGIN)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_word  (push_word),
    .stall_mode (ovf_stall),
    .q_full     (q_full),
    .q_cnt      (q_cnt),
    .stall      (core_stall),
    .out_valid  (msg_valid),
    .out_ready  (msg_ready),
    .out_word   (out_word)
  );

  assign {msg_kind, msg_flow, msg_len, msg_addr} = out_word;

endmodule

// File: rtl/brtrace_enc_chk.sv
module brtrace_enc_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int LW  = $clog2(AW / 8),
  localparam int CTW = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           ovf_stall,
  input logic           core_stall,
  input logic           msg_valid,
  input logic           msg_ready,
  input logic [1:0]     msg_kind,
  input logic [2:0]     msg_flow,
  input logic [LW-1:0]  msg_len,
  input logic [AW-1:0]  msg_addr,
  input logic           push,
  input logic [1:0]     push_kind,
  input logic           q_full,
  input logic [CTW-1:0] q_cnt
);

  logic err_seen;

  always_ff @(posedge clk) begin
    if (rst)       err_seen <= 1'b0;
    else if (push) err_seen <= (push_kind == 2'd3);
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!msg_valid && !core_stall));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable({msg_kind, msg_flow, msg_len, msg_addr})));

  assert_trim_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == 2'd1) |-> ((msg_addr >> ((6'(msg_len) + 6'd1) * 6'd8)) == '0));

  assert_sync_len_R4: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == 2'd2) |-> (msg_len == LW'((AW / 8) - 1)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !q_full);

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= CTW'(DEPTH));

  assert_err_then_sync_R9: assert property (@(posedge clk) disable iff (rst)
    (push && err_seen) |-> (push_kind == 2'd2));

  assert_drop_mode_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(ovf_stall) |-> !core_stall);

endmodule

bind brtrace_enc brtrace_enc_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ovf_stall  (ovf_stall),
  .core_stall (core_stall),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_kind   (msg_kind),
  .msg_flow   (msg_flow),
  .msg_len    (msg_len),
  .msg_addr   (msg_addr),
  .push       (push),
  .push_kind  (push_kind),
  .q_full     (q_full),
  .q_cnt      (q_cnt)
);

// File: tb/brtrace_enc_bench.sv
module brtrace_enc_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trc_en = 1'b0, trc_start = 1'b0, trc_stop = 1'b0, ovf_stall = 1'b0;
  logic        ret_valid = 1'b0;
  logic [2:0]  ret_flow = 3'd0;
  logic [31:0] ret_target = '0;
  logic        core_stall, msg_valid;
  logic        msg_ready = 1'b1;
  logic [1:0]  msg_kind;
  logic [2:0]  msg_flow;
  logic [1:0]  msg_len;
  logic [31:0] msg_addr;

  int checks = 0, failures = 0, cycles = 0;
  logic [38:0] exp_q[$];
  string       tag_q[$];

  logic        m_need = 1'b1;
  int          m_cnt = 0;
  logic [31:0] m_last = '0;
  logic        hold_ready = 1'b0, toggle_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brtrace_enc u_brtrace_enc (
    .clk(clk), .rst(rst), .trc_en(trc_en), .trc_start(trc_start), .trc_stop(trc_stop),
    .ovf_stall(ovf_stall), .ret_valid(ret_valid), .ret_flow(ret_flow), .ret_target(ret_target),
    .core_stall(core_stall), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_flow(msg_flow), .msg_len(msg_len), .msg_addr(msg_addr)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      report();
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    msg_ready <= hold_ready ? 1'b0 : (toggle_ready ? lfsr[0] : 1'b1);
  end

  // Monitor: compare each accepted message against the scoreboard.
  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        check("R2/R3 unexpected message", {25'd0, msg_kind, msg_flow, msg_len, msg_addr}, 64'd0);
      end else begin
        check(tag_q.pop_front(), {25'd0, msg_kind, msg_flow, msg_len, msg_addr},
              {25'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [1:0] len_of(input logic [31:0] x);
    logic [1:0] l = 2'd0;
    for (int i = 1; i < 4; i++) if (x[8*i +: 8] != 8'd0) l = 2'(i);
    return l;
  endfunction

  // Model of R4/R5/R6 applied to an accepted flow change.
  task automatic expect_flow(input logic [2:0] f, input logic [31:0] t, input string stag);
    logic [31:0] d;
    if (f == 3'd0 || f == 3'd3) return;
    if (m_need || m_cnt == 256) begin
      exp_q.push_back({2'd2, f, 2'd3, t});
      tag_q.push_back(m_cnt == 256 && !m_need ? "R6 sync after period" : stag);
      m_need = 1'b0;
      m_cnt  = 0;
    end else begin
      d = t ^ m_last;
      exp_q.push_back({2'd1, f, len_of(d), d});
      tag_q.push_back("R5 normal");
      m_cnt++;
    end
    m_last = t;
  endtask

  task automatic drive(input logic [2:0] f, input logic [31:0] t);
    ret_valid = 1'b1; ret_flow = f; ret_target = t;
    step();
    ret_valid = 1'b0;
    step();
  endtask

  task automatic send(input logic [2:0] f, input logic [31:0] t, input string stag = "R4 sync");
    expect_flow(f, t, stag);
    drive(f, t);
  endtask

  task automatic pulse_start();
    trc_start = 1'b1; step(); trc_start = 1'b0; step();
    m_need = 1'b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (exp_q.size() != 0 || msg_valid); i++) step();
    step(3);
    check("R7 scoreboard empty", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    step(3);
    check("R1 valid in reset", {63'd0, msg_valid}, 64'd0);
    check("R1 stall in reset", {63'd0, core_stall}, 64'd0);
    rst = 1'b0;
    step();
    check("R1 valid after reset", {63'd0, msg_valid}, 64'd0);

    // R3: enabled but never started.
    trc_en = 1'b1;
    drive(3'd1, 32'h0000_4000);
    drive(3'd5, 32'h0000_5000);
    step(4);
    check("R3 no message before start", {63'd0, msg_valid}, 64'd0);

    // R4, R5, R2: first messages after start.
    pulse_start();
    send(3'd1, 32'h1000_0000);
    send(3'd2, 32'h1000_0004);
    send(3'd0, 32'h1000_0008);
    send(3'd3, 32'h1000_000C);
    send(3'd4, 32'h1000_0104);
    send(3'd5, 32'h8000_0104);
    send(3'd6, 32'h8000_0104);
    send(3'd7, 32'h8012_0104);
    drain();
    drive(3'd0, 32'h1234_5678);
    drive(3'd3, 32'h1234_5678);
    step(4);
    check("R2 no message for codes 0 and 3", {63'd0, msg_valid}, 64'd0);

    // R7: burst under an irregular ready pattern.
    toggle_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      expect_flow(3'(1 + (i % 2)), {lfsr, 16'h0} ^ 32'(i * 36), "R7 order");
      ret_valid = 1'b1; ret_flow = 3'(1 + (i % 2)); ret_target = {lfsr, 16'h0} ^ 32'(i * 36);
      step();
    end
    ret_valid = 1'b0;
    drain();
    toggle_ready = 1'b0;

    // R6: long run forces a periodic sync.
    for (int i = 0; i < 270; i++) send(3'd2, 32'h2000_0000 + 32'(i * 8));
    drain();

    // R3: after stop, nothing.
    trc_stop = 1'b1; step(); trc_stop = 1'b0; step();
    drive(3'd1, 32'h3000_0000);
    drive(3'd6, 32'h3000_1000);
    step(4);
    check("R3 no message after stop", {63'd0, msg_valid}, 64'd0);
    pulse_start();
    send(3'd6, 32'h3000_2000, "R4 sync after restart");
    drain();

    // R8, R9, R10: drop policy under a blocked link.
    ovf_stall = 1'b0;
    hold_ready = 1'b1;
    step(2);
    for (int i = 0; i < 17; i++) send(3'd1, 32'h4000_0000 + 32'(i * 16));
    for (int i = 0; i < 3; i++) drive(3'd1, 32'h5000_0000 + 32'(i * 16));
    step(3);
    check("R10 no stall in drop mode", {63'd0, core_stall}, 64'd0);
    check("R8 head held while full", {63'd0, msg_valid}, 64'd1);
    exp_q.push_back({2'd3, 3'd0, 2'd0, 32'd0});
    tag_q.push_back("R8 error message");
    m_need = 1'b1;
    hold_ready = 1'b0;
    drain();
    send(3'd4, 32'h6000_0040, "R9 sync after error");
    drain();

    // R10: stall threshold.
    ovf_stall = 1'b1;
    hold_ready = 1'b1;
    step(2);
    for (int i = 0; i < 14; i++) send(3'd2, 32'h7000_0000 + 32'(i * 4));
    step(3);
    check("R10 no stall with 3 free", {63'd0, core_stall}, 64'd0);
    send(3'd2, 32'h7000_1000);
    step(3);
    check("R10 stall with 2 free", {63'd0, core_stall}, 64'd1);
    hold_ready = 1'b0;
    drain();
    check("R10 stall released", {63'd0, core_stall}, 64'd0);

    report();
  end

endmodule